// File: doc/BRIEF.md
# Eight-Channel Block Copy Engine

The block moves bytes between a 24-bit memory space, addressed by an 8-bit bank and a 16-bit offset, and an 8-bit register port. Each of its eight channels has a small byte-wide register file. Software fills in a channel's control byte, port address, memory address, bank and byte count. It then writes a start mask that names any set of channels.

Once launched, the engine spends one overhead cycle on the batch. It then takes the flagged channels one at a time, lowest index first. Each channel gets one overhead cycle of its own and then one copy cycle per byte. On every copy cycle the engine presents a request that carries the memory address, the port address and the direction, and the surrounding fabric moves that byte.

The port address follows a short repeating offset pattern chosen by the channel's mode. The memory address can stay fixed, step up or step down, and it wraps within 16 bits. While the engine is working it holds a busy output high. The processor side is held off for that time, so register writes and new start requests are dropped.

Top module: `dma_engine`

## Requirements
- R1: After reset every channel register reads 0xff, the 16-bit registers read 0xffff in both halves, the control byte reads 0xff (mode 7, all flags set), and busy_o and mem_req_o are low.
- R2: The register address is {channel, offset[3:0]}. The offsets are: 0 control, 1 port address, 2/3 memory address low/high, 4 bank, 5/6 count low/high, 7 spare bank, 8/9 spare 16-bit word low/high, 0xa spare counter byte. Offsets 0xb and 0xf share one scratch byte. Offsets 0xc to 0xe read 0x00 and ignore writes. Writing one half of a 16-bit register leaves the other half unchanged.
- R3: The control byte holds mode in bits 2:0, hold-address in bit 3, step-down in bit 4, a stored-only bit in bit 5, an indirect flag (stored only) in bit 6, and direction in bit 7. Every bit reads back as written.
- R4: A start pulse with a nonzero mask while idle raises busy_o on the next cycle. A start pulse with a zero mask has no effect. Start pulses and register writes are ignored while busy_o is high.
- R5: A batch with channel set S and byte counts n_i keeps busy_o high for exactly 1 + sum over S of (1 + n_i) cycles. The cycle order is the batch overhead cycle, then for each channel in S in ascending index one overhead cycle with mem_req_o low followed by n_i cycles with mem_req_o high.
- R6: On the k-th byte of a channel (k counted from 0), mem_b_addr_o is the port address plus an offset, wrapping at 8 bits. The offset depends on the mode and on k mod 4: mode 0, 2 and 6 give 0; modes 1 and 5 give k mod 2; modes 3 and 7 give (k mod 4)/2; mode 4 gives k mod 4.
- R7: mem_a_addr_o is {bank, address}. After each byte the address is unchanged if bit 3 is set, otherwise it steps by -1 if bit 4 is set and by +1 if not, wrapping within 16 bits and never changing the bank. After the batch the register reads back the final address and a count of zero.
- R8: A count of 0 moves 65536 bytes.
- R9: mem_req_o is high only while busy_o is high, and mem_dir_o equals bit 7 of the serviced channel's control byte (1 means port to memory).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register address {channel, offset} |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| start_i | input | 1 | Start strobe |
| start_mask_i | input | 8 | Channels to launch, bit i for channel i |
| busy_o | output | 1 | Engine working; processor side held off |
| mem_req_o | output | 1 | One byte copy requested this cycle |
| mem_dir_o | output | 1 | 1: port to memory, 0: memory to port |
| mem_a_addr_o | output | 24 | Memory address {bank, address} |
| mem_b_addr_o | output | 8 | Port address |

## Verification
Register writes take effect on the edge that samples them, and combinational reads see the new value on the next falling edge. A start pulse sampled at one edge produces the batch overhead cycle immediately after that edge. The checks follow the R5 schedule from there, one clock per step: for every channel, one overhead cycle and then one request cycle per byte, with busy_o expected low on the cycle after the last byte. All outputs are sampled on the falling edge, so each expected address is compared in exactly the cycle its registers settle. Final addresses and counts are read back only once busy_o has dropped.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned OFS_W = 4;

  typedef struct packed {
    logic       from_b;
    logic       indir;
    logic       spare;
    logic       dec;
    logic       fixed;
    logic [2:0] mode;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_HEAD, ST_CHAN, ST_MOVE} st_e;

  localparam ctrl_t CTRL_RST = ctrl_t'(8'hff);

  // port-side offset for byte phase ph under a given mode
  function automatic logic [1:0] b_step(input logic [2:0] mode, input logic [1:0] ph);
    case (mode)
      3'd1, 3'd5: b_step = {1'b0, ph[0]};
      3'd3, 3'd7: b_step = {1'b0, ph[1]};
      3'd4:       b_step = ph;
      default:    b_step = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [OFS_W-1:0] wr_off_i,
  input  logic [7:0]       wr_data_i,
  input  logic             step_i,
  input  logic [OFS_W-1:0] rd_off_i,
  output logic [7:0]       rd_data_o,
  output logic [2:0]       mode_o,
  output logic             from_b_o,
  output logic [7:0]       b_o,
  output logic [15:0]      a_o,
  output logic [7:0]       bank_o,
  output logic [15:0]      cnt_o
);
  ctrl_t       ctrl_q;
  logic [7:0]  b_q, bank_q, ibank_q, line_q, spare_q;
  logic [15:0] a_q, cnt_q, tbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      b_q     <= 8'hff;
      bank_q  <= 8'hff;
      ibank_q <= 8'hff;
      line_q  <= 8'hff;
      spare_q <= 8'hff;
      a_q     <= 16'hffff;
      cnt_q   <= 16'hffff;
      tbl_q   <= 16'hffff;
    end else if (wr_en_i) begin
      case (wr_off_i)
        4'h0: ctrl_q       <= ctrl_t'(wr_data_i);
        4'h1: b_q          <= wr_data_i;
        4'h2: a_q[7:0]     <= wr_data_i;
        4'h3: a_q[15:8]    <= wr_data_i;
        4'h4: bank_q       <= wr_data_i;
        4'h5: cnt_q[7:0]   <= wr_data_i;
        4'h6: cnt_q[15:8]  <= wr_data_i;
        4'h7: ibank_q      <= wr_data_i;
        4'h8: tbl_q[7:0]   <= wr_data_i;
        4'h9: tbl_q[15:8]  <= wr_data_i;
        4'ha: line_q       <= wr_data_i;
        4'hb, 4'hf: spare_q <= wr_data_i;
        default: ;
      endcase
    end else if (step_i) begin
      if (!ctrl_q.fixed) a_q <= ctrl_q.dec ? a_q - 16'd1 : a_q + 16'd1;
      cnt_q <= cnt_q - 16'd1;
    end
  end

  always_comb begin
    case (rd_off_i)
      4'h0: rd_data_o = ctrl_q;
      4'h1: rd_data_o = b_q;
      4'h2: rd_data_o = a_q[7:0];
      4'h3: rd_data_o = a_q[15:8];
      4'h4: rd_data_o = bank_q;
      4'h5: rd_data_o = cnt_q[7:0];
      4'h6: rd_data_o = cnt_q[15:8];
      4'h7: rd_data_o = ibank_q;
      4'h8: rd_data_o = tbl_q[7:0];
      4'h9: rd_data_o = tbl_q[15:8];
      4'ha: rd_data_o = line_q;
      4'hb, 4'hf: rd_data_o = spare_q;
      default: rd_data_o = 8'h00;
    endcase
  end

  assign mode_o   = ctrl_q.mode;
  assign from_b_o = ctrl_q.from_b;
  assign b_o      = b_q;
  assign a_o      = a_q;
  assign bank_o   = bank_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/dma_sched.sv
module dma_sched
  import dma_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_CH-1:0] start_mask_i,
  input  logic [15:0]       cur_cnt_i,
  output logic              busy_o,
  output logic              move_o,
  output logic [CH_W-1:0]   cur_o,
  output logic [1:0]        phase_o
);
  st_e               st_q;
  logic [NUM_CH-1:0] act_q, rest;
  logic [CH_W-1:0]   cur_q;
  logic [1:0]        ph_q;

  function automatic logic [CH_W-1:0] lowest(input logic [NUM_CH-1:0] v);
    lowest = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) if (v[i]) lowest = CH_W'(i);
  endfunction

  assign rest = act_q & ~(NUM_CH'(1) << cur_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      act_q <= '0;
      cur_q <= '0;
      ph_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i && |start_mask_i) begin
          act_q <= start_mask_i;
          st_q  <= ST_HEAD;
        end
        ST_HEAD: begin
          cur_q <= lowest(act_q);
          st_q  <= ST_CHAN;
        end
        ST_CHAN: begin
          ph_q <= '0;
          st_q <= ST_MOVE;
        end
        ST_MOVE: begin
          ph_q <= ph_q + 2'd1;
          if (cur_cnt_i == 16'd1) begin
            act_q <= rest;
            if (|rest) begin
              cur_q <= lowest(rest);
              st_q  <= ST_CHAN;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign move_o  = (st_q == ST_MOVE);
  assign cur_o   = cur_q;
  assign phase_o = ph_q;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_pkg::*;
(
  input  logic [2:0]  mode_i,
  input  logic [1:0]  phase_i,
  input  logic [7:0]  b_i,
  input  logic [15:0] a_i,
  input  logic [7:0]  bank_i,
  output logic [23:0] a_addr_o,
  output logic [7:0]  b_addr_o
);
  assign a_addr_o = {bank_i, a_i};
  assign b_addr_o = b_i + {6'd0, b_step(mode_i, phase_i)};
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [CH_W+OFS_W-1:0] reg_addr_i,
  input  logic [7:0]            reg_wdata_i,
  output logic [7:0]            reg_rdata_o,
  input  logic                  start_i,
  input  logic [NUM_CH-1:0]     start_mask_i,
  output logic                  busy_o,
  output logic                  mem_req_o,
  output logic                  mem_dir_o,
  output logic [23:0]           mem_a_addr_o,
  output logic [7:0]            mem_b_addr_o
);
  logic [CH_W-1:0]  reg_ch, cur;
  logic [OFS_W-1:0] reg_off;
  logic             move;
  logic [1:0]       phase;

  logic [7:0]  rd_a   [NUM_CH];
  logic [2:0]  mode_a [NUM_CH];
  logic        dir_a  [NUM_CH];
  logic [7:0]  b_a    [NUM_CH];
  logic [15:0] a_a    [NUM_CH];
  logic [7:0]  bank_a [NUM_CH];
  logic [15:0] cnt_a  [NUM_CH];

  assign reg_ch  = reg_addr_i[CH_W+OFS_W-1:OFS_W];
  assign reg_off = reg_addr_i[OFS_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dma_chan_regs u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (reg_we_i && !busy_o && (reg_ch == CH_W'(g))),
      .wr_off_i  (reg_off),
      .wr_data_i (reg_wdata_i),
      .step_i    (move && (cur == CH_W'(g))),
      .rd_off_i  (reg_off),
      .rd_data_o (rd_a[g]),
      .mode_o    (mode_a[g]),
      .from_b_o  (dir_a[g]),
      .b_o       (b_a[g]),
      .a_o       (a_a[g]),
      .bank_o    (bank_a[g]),
      .cnt_o     (cnt_a[g])
    );
  end

  always_comb begin
    reg_rdata_o = 8'h00;
    for (int i = 0; i < NUM_CH; i++) if (reg_ch == CH_W'(i)) reg_rdata_o = rd_a[i];
  end

  dma_sched #(.NUM_CH(NUM_CH)) u_sched (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_mask_i (start_mask_i),
    .cur_cnt_i    (cnt_a[cur]),
    .busy_o       (busy_o),
    .move_o       (move),
    .cur_o        (cur),
    .phase_o      (phase)
  );

  dma_addr_gen u_agen (
    .mode_i   (mode_a[cur]),
    .phase_i  (phase),
    .b_i      (b_a[cur]),
    .a_i      (a_a[cur]),
    .bank_i   (bank_a[cur]),
    .a_addr_o (mem_a_addr_o),
    .b_addr_o (mem_b_addr_o)
  );

  assign mem_req_o = move;
  assign mem_dir_o = dir_a[cur];
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [NUM_CH-1:0] start_mask_i,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic [23:0]       mem_a_addr_o
);
  p_req_in_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  p_head_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !mem_req_o);

  p_launch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (|start_mask_i)) |=> busy_o);

  p_empty_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (start_mask_i == '0)) |=> !busy_o);

  p_addr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |->
      ($stable(mem_a_addr_o[23:16]) &&
       (16'(mem_a_addr_o[15:0] - $past(mem_a_addr_o[15:0])) inside {16'h0000, 16'h0001, 16'hffff})));
endmodule

bind dma_engine dma_engine_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .start_mask_i (start_mask_i),
  .busy_o       (busy_o),
  .mem_req_o    (mem_req_o),
  .mem_a_addr_o (mem_a_addr_o)
);

// File: tb/sim_dma_engine.sv
module sim_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        start = 1'b0;
  logic [7:0]  start_mask = '0;
  logic        busy, req, dir;
  logic [23:0] a_addr;
  logic [7:0]  b_addr;

  always #4 clk = ~clk;

  dma_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .start_i(start),
    .start_mask_i(start_mask), .busy_o(busy), .mem_req_o(req), .mem_dir_o(dir),
    .mem_a_addr_o(a_addr), .mem_b_addr_o(b_addr)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0]  sh_ctrl [8];
  logic [7:0]  sh_b    [8];
  logic [7:0]  sh_bank [8];
  logic [15:0] sh_a    [8];
  logic [15:0] sh_cnt  [8];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int off, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {3'(ch), 4'(off)}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output logic [7:0] d);
    @(negedge clk);
    reg_addr = {3'(ch), 4'(off)};
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] exp_ofs(input logic [2:0] mode, input int k);
    int p = k % 4;
    if (mode == 3'd4) return 8'(p);
    if (mode == 3'd1 || mode == 3'd5) return 8'(p % 2);
    if (mode == 3'd3 || mode == 3'd7) return 8'(p / 2);
    return 8'd0;
  endfunction

  task automatic setup(input int ch, input logic [7:0] c, input logic [7:0] b,
                       input logic [15:0] a, input logic [7:0] bk, input logic [15:0] n);
    wr(ch, 0, c); wr(ch, 1, b); wr(ch, 2, a[7:0]); wr(ch, 3, a[15:8]);
    wr(ch, 4, bk); wr(ch, 5, n[7:0]); wr(ch, 6, n[15:8]);
    sh_ctrl[ch] = c; sh_b[ch] = b; sh_a[ch] = a; sh_bank[ch] = bk; sh_cnt[ch] = n;
  endtask

  // steps through the expected schedule one cycle at a time
  task automatic run(input logic [7:0] m, input bit poke);
    bit bad = 0;
    string tag = "R5 trace";
    logic [31:0] ga = 0, ge = 0;
    @(negedge clk);
    start = 1'b1; start_mask = m;
    @(negedge clk);
    start = 1'b0; start_mask = '0;
    if (!bad && {busy, req} !== 2'b10) begin bad = 1; tag = "R5 head"; ga = {busy, req}; ge = 2'b10; end
    if (poke) begin
      start = 1'b1; start_mask = 8'hff;
      reg_we = 1'b1; reg_addr = {3'd7, 4'h1}; reg_wdata = ~sh_b[7];
    end
    @(negedge clk);
    start = 1'b0; start_mask = '0; reg_we = 1'b0;
    for (int ch = 0; ch < 8; ch++) begin
      int n;
      if (!m[ch]) continue;
      n = (sh_cnt[ch] == 0) ? 65536 : int'(sh_cnt[ch]);
      if (!bad && {busy, req} !== 2'b10) begin bad = 1; tag = "R5 chan ovh"; ga = {busy, req}; ge = 2'b10; end
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
        if (!bad && {busy, req} !== 2'b11) begin bad = 1; tag = "R5 byte"; ga = {busy, req}; ge = 2'b11; end
        if (!bad && a_addr !== {sh_bank[ch], sh_a[ch]}) begin bad = 1; tag = "R7 A addr"; ga = a_addr; ge = {sh_bank[ch], sh_a[ch]}; end
        if (!bad && b_addr !== 8'(sh_b[ch] + exp_ofs(sh_ctrl[ch][2:0], k))) begin
          bad = 1; tag = "R6 B addr"; ga = b_addr; ge = 8'(sh_b[ch] + exp_ofs(sh_ctrl[ch][2:0], k));
        end
        if (!bad && dir !== sh_ctrl[ch][7]) begin bad = 1; tag = "R9 dir"; ga = dir; ge = sh_ctrl[ch][7]; end
        if (!sh_ctrl[ch][3]) sh_a[ch] = sh_ctrl[ch][4] ? sh_a[ch] - 16'd1 : sh_a[ch] + 16'd1;
        @(negedge clk);
      end
      sh_cnt[ch] = 16'd0;
    end
    if (!bad && {busy, req} !== 2'b00) begin bad = 1; tag = "R5 end"; ga = {busy, req}; ge = 2'b00; end
    check(tag, ga, ge);
  endtask

  task automatic readback(input logic [7:0] m);
    logic [7:0] lo, hi;
    for (int ch = 0; ch < 8; ch++) begin
      if (!m[ch]) continue;
      rd(ch, 2, lo); rd(ch, 3, hi);
      check("R7 final addr", {lo, hi} == 0 ? {hi, lo} : {hi, lo}, sh_a[ch]);
      rd(ch, 5, lo); rd(ch, 6, hi);
      check("R7 final count", {hi, lo}, 16'd0);
      rd(ch, 4, lo);
      check("R7 bank kept", lo, sh_bank[ch]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1a2b3c));
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 1'b0);
    check("R1 req", req, 1'b0);
    rst_n = 1'b1;

    // R1 reset image; R2 unmapped offsets read zero
    for (int ch = 0; ch < 8; ch++)
      for (int off = 0; off < 16; off++) begin
        rd(ch, off, d);
        check((off >= 12 && off <= 14) ? "R2 unmapped" : "R1 reset value", d,
              (off >= 12 && off <= 14) ? 8'h00 : 8'hff);
      end
    for (int ch = 0; ch < 8; ch++) begin
      sh_ctrl[ch] = 8'hff; sh_b[ch] = 8'hff; sh_bank[ch] = 8'hff;
      sh_a[ch] = 16'hffff; sh_cnt[ch] = 16'hffff;
    end

    // R2 half writes and shared scratch byte
    wr(1, 2, 8'h34); rd(1, 3, d); check("R2 high half kept", d, 8'hff);
    rd(1, 2, d); check("R2 low half", d, 8'h34);
    wr(1, 9, 8'h5c); rd(1, 8, d); check("R2 low half kept", d, 8'hff);
    wr(1, 11, 8'ha7); rd(1, 15, d); check("R2 shared scratch", d, 8'ha7);
    wr(1, 15, 8'h3e); rd(1, 11, d); check("R2 shared scratch", d, 8'h3e);
    wr(1, 13, 8'h11); rd(1, 13, d); check("R2 unmapped write", d, 8'h00);
    wr(1, 10, 8'h42); rd(1, 10, d); check("R2 counter byte", d, 8'h42);
    sh_a[1] = 16'hff34;

    // R3 control bits read back
    wr(2, 0, 8'h6a); rd(2, 0, d); check("R3 control", d, 8'h6a);
    wr(2, 0, 8'h95); rd(2, 0, d); check("R3 control", d, 8'h95);
    sh_ctrl[2] = 8'h95;

    // R4 empty mask
    @(negedge clk); start = 1'b1; start_mask = 8'h00;
    @(negedge clk); start = 1'b0;
    check("R4 empty mask", busy, 1'b0);

    // R6 mode 4 directed, R7 wrap upward and downward
    setup(0, 8'h04, 8'h10, 16'h1000, 8'h7e, 16'd6);
    setup(2, 8'h83, 8'hfe, 16'hffff, 8'h20, 16'd5);
    setup(5, 8'h11, 8'h40, 16'h0001, 8'h21, 16'd3);
    run(8'h25, 1'b0);
    readback(8'h25);

    // constrained random batches
    for (int it = 0; it < 20; it++) begin
      logic [7:0] m;
      m = 8'($urandom_range(1, 255));
      for (int ch = 0; ch < 8; ch++)
        if (m[ch])
          setup(ch, 8'($urandom), 8'($urandom), 16'($urandom), 8'($urandom),
                16'($urandom_range(1, 7)));
      run(m, 1'b0);
      readback(m);
    end

    // R8 count zero, fixed address; R4 writes and starts during busy dropped
    setup(3, 8'h0f, 8'h22, 16'h8000, 8'h05, 16'd0);
    run(8'h08, 1'b1);
    readback(8'h08);
    rd(7, 1, d); check("R4 write while busy", d, sh_b[7]);
    check("R8 after 65536", busy, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule